// File: doc/BRIEF.md
# Trace Buffer Writer

The trace buffer writer collects captured data words from a monitoring pipeline and lays them down, one after another, in a linear memory region. Each incoming packet carries a 64-bit value and a tag for the kind of event that produced it: an indirect-call target, a sensitive-return target or a constraint-data value. All three kinds share one region. Each value goes to memory unchanged, and the words appear in memory in the order the packets were accepted.

Software sets the region with three registers: a base address, a size in bytes and a write pointer. When the pointer reaches the end of the region, the block raises an interrupt. While the interrupt is pending, memory writes stop. The block still takes one more packet into an internal slot, so that packet is neither lost nor written past the end. Software then empties the region and acknowledges. The acknowledge rewinds the pointer to the base and clears the interrupt. The held packet becomes the first word of the new pass, and collection resumes.

Top module: `trace_buf_writer`

## Requirements
- R1: After reset, `irq` and `mem_we` are low, `pkt_ready` is high, and `wr_ptr` equals the reset base parameter. The reset base is 0x1000 and the reset size is 0x40 bytes (eight words).
- R2: A packet accepted while the region is not full and the hold slot is empty is written in the next cycle. In that cycle `mem_we` is high, `mem_addr` holds the pointer value from before the write, and `mem_wdata` holds `pkt_data` exactly. The pointer then advances by 8.
- R3: Packets from all three sources go to the same region in the order they were accepted. The source codes are 0 for an indirect-call target, 1 for a return target and 2 for constraint data. The source tag is never stored.
- R4: `irq` is high exactly when `wr_ptr` equals base plus size. No memory write is issued in the cycle after one in which `irq` is high.
- R5: While `irq` is high and the hold slot is empty, `pkt_ready` stays high. A packet accepted in that state goes into the hold slot and is not written.
- R6: An `irq_ack` pulse while `irq` is high sets `wr_ptr` to the base and drops `irq` in the next cycle. The held packet, if there is one, is written at the base address in the cycle after that.
- R7: An `irq_ack` pulse while `irq` is low has no effect: the pointer and all later write addresses are unchanged.
- R8: A configuration write with `cfg_sel` = 0 sets both the base and the pointer. With `cfg_sel` = 1 it sets the size in bytes. With `cfg_sel` = 2 it sets only the pointer. The new values take effect in the next cycle.
- R9: `pkt_ready` is low exactly while the hold slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be taken this cycle |
| pkt_src | input | 2 | Source tag (0 call, 1 return, 2 constraint data) |
| pkt_data | input | 64 | Captured data word |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 pointer |
| cfg_wdata | input | 32 | Configuration write value |
| wr_ptr | output | 32 | Current write pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| irq | output | 1 | Region full interrupt |
| irq_ack | input | 1 | Software acknowledge after emptying the region |

## Verification
The assertions assume that software writes configuration only in cycles with no packet traffic and no acknowledge. They also assume that the size is a nonzero multiple of 8, that the pointer stays inside the region, and that a packet never carries source code 3. The stimulus programs the region between bursts, with the input idle, and draws source tags only from the three legal codes. Acknowledges are issued both while the interrupt is pending and while it is not. A bench model that tracks the pointer and hold slot from the requirements is compared with the outputs after every clock.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    typedef enum logic [1:0] {
        SRC_ICALL = 2'd0,
        SRC_RET   = 2'd1,
        SRC_CDATA = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_SIZE = 2'd1,
        CFG_PTR  = 2'd2
    } cfg_sel_e;

    typedef enum logic [1:0] {
        PTR_KEEP   = 2'd0,
        PTR_ADV    = 2'd1,
        PTR_REWIND = 2'd2,
        PTR_LOAD   = 2'd3
    } ptr_op_e;

    function automatic int unsigned bytes_per_word(int unsigned dw);
        return dw / 8;
    endfunction

endpackage

// File: rtl/tbw_region_ctrl.sv
module tbw_region_ctrl
    import tbw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STEP     = 8,
    parameter logic [ADDR_W-1:0] RST_BASE = 'h1000,
    parameter logic [ADDR_W-1:0] RST_SIZE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              adv,
    input  logic              ack,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic              full_o
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    logic [ADDR_W-1:0] base_q, size_q, ptr_q, ptr_load;
    logic              full;
    ptr_op_e           op;
    cfg_sel_e          sel;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign limit_o = base_q + size_q;
    assign full    = (ptr_q == limit_o);
    assign full_o  = full;
    assign ptr_o   = ptr_q;
    assign base_o  = base_q;

    always_comb begin
        op       = PTR_KEEP;
        ptr_load = cfg_wdata;
        if (ack && full)
            op = PTR_REWIND;
        else if (cfg_we && (sel == CFG_BASE || sel == CFG_PTR))
            op = PTR_LOAD;
        else if (adv)
            op = PTR_ADV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= RST_BASE;
            size_q <= RST_SIZE;
            ptr_q  <= RST_BASE;
        end else begin
            if (cfg_we && sel == CFG_BASE) base_q <= cfg_wdata;
            if (cfg_we && sel == CFG_SIZE) size_q <= cfg_wdata;
            case (op)
                PTR_ADV:    ptr_q <= ptr_q + STEP_A;
                PTR_REWIND: ptr_q <= base_q;
                PTR_LOAD:   ptr_q <= ptr_load;
                default:    ptr_q <= ptr_q;
            endcase
        end
    end

    // R6: acknowledge during full rewinds the pointer to the base
    assert_ack_rewinds_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && full) |=> (ptr_q == $past(base_q)));

    // R7: acknowledge with no pending full leaves the pointer alone
    assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !full && !cfg_we && !adv) |=> $stable(ptr_q));

    // R2: each issued write moves the pointer by one word
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !ack && !cfg_we) |=> (ptr_q == $past(ptr_q) + STEP_A));

    // R8: base write loads base and pointer together
    assert_base_load_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0 && !(ack && full)) |=>
        (base_q == $past(cfg_wdata) && ptr_q == $past(cfg_wdata)));

endmodule

// File: rtl/tbw_hold_slot.sv
module tbw_hold_slot #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drain,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else if (load) begin
            v_q <= 1'b1;
            d_q <= load_data;
        end else if (drain) begin
            v_q <= 1'b0;
        end
    end

    assign valid_o = v_q;
    assign data_o  = d_q;

    // R5: a load never lands on an occupied slot
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> !v_q);

endmodule

// File: rtl/tbw_write_port.sv
module tbw_write_port #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= go;
            if (go) begin
                mem_addr  <= addr;
                mem_wdata <= data;
            end
        end
    end

    // R2: written word is the one presented in the issuing cycle
    assert_data_raw_R2: assert property (@(posedge clk) disable iff (rst)
        go |=> (mem_we && mem_wdata == $past(data) && mem_addr == $past(addr)));

endmodule

// File: rtl/trace_buf_writer.sv
module trace_buf_writer
    import tbw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 64,
    parameter logic [ADDR_W-1:0] RST_BASE = 'h1000,
    parameter logic [ADDR_W-1:0] RST_SIZE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [1:0]        pkt_src,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq,
    input  logic              irq_ack
);
    localparam int unsigned STEP = bytes_per_word(DATA_W);

    logic              full, hold_v, accept, direct, to_hold, drain, adv;
    logic [DATA_W-1:0] hold_d, wr_data;
    logic [ADDR_W-1:0] base, limit;

    assign pkt_ready = !hold_v;
    assign accept    = pkt_valid && pkt_ready;
    assign direct    = accept && !full;
    assign to_hold   = accept && full;
    assign drain     = hold_v && !full;
    assign adv       = direct || drain;
    assign wr_data   = drain ? hold_d : pkt_data;
    assign irq       = full;

    tbw_region_ctrl #(
        .ADDR_W(ADDR_W), .STEP(STEP), .RST_BASE(RST_BASE), .RST_SIZE(RST_SIZE)
    ) u_region (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .adv(adv), .ack(irq_ack),
        .ptr_o(wr_ptr), .base_o(base), .limit_o(limit), .full_o(full)
    );

    tbw_hold_slot #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst),
        .load(to_hold), .load_data(pkt_data), .drain(drain),
        .valid_o(hold_v), .data_o(hold_d)
    );

    tbw_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
        .clk(clk), .rst(rst),
        .go(adv), .addr(wr_ptr), .data(wr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // R4: nothing is written in the cycle after a full cycle
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !mem_we);

    // R4: every write lands inside the configured region
    assert_addr_in_region_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(cfg_we)) |-> (mem_addr >= base && mem_addr < limit));

    // R5: a packet taken while full occupies the slot and closes the input
    assert_hold_closes_R5: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && irq) |=> !pkt_ready);

    // R3: only the three defined source codes appear
    assert_src_known_R3: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_src != 2'd3));

endmodule

// File: tb/tb_trace_buf_writer.sv
`timescale 1ns/1ps
module tb_trace_buf_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [1:0]  pkt_src = 2'd0;
    logic [63:0] pkt_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] wr_ptr;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        irq;
    logic        irq_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    trace_buf_writer dut (
        .clk(clk), .rst(rst),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_src(pkt_src), .pkt_data(pkt_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .wr_ptr(wr_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq), .irq_ack(irq_ack)
    );

    // behavioural reference state
    logic [31:0] m_base = 32'h1000;
    logic [31:0] m_size = 32'h40;
    logic [31:0] m_ptr  = 32'h1000;
    logic [63:0] m_hold[$];
    logic        e_we = 1'b0;
    logic [31:0] e_addr = '0;
    logic [63:0] e_data = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(mem_we == e_we, "R2 mem_we", 64'(mem_we), 64'(e_we));
        if (e_we) begin
            chk(mem_addr == e_addr, "R2 mem_addr", 64'(mem_addr), 64'(e_addr));
            chk(mem_wdata == e_data, "R3 mem_wdata order", mem_wdata, e_data);
        end
        chk(irq == (m_ptr == m_base + m_size), "R4 irq", 64'(irq),
            64'(m_ptr == m_base + m_size));
        chk(pkt_ready == (m_hold.size() == 0), "R9 pkt_ready", 64'(pkt_ready),
            64'(m_hold.size() == 0));
        chk(wr_ptr == m_ptr, "R8 wr_ptr", 64'(wr_ptr), 64'(m_ptr));
    endtask

    // one clock with the inputs currently driven; returns whether a packet was taken
    task automatic step(output bit taken);
        bit          full;
        logic [31:0] n_ptr, n_base, n_size;
        full   = (m_ptr == m_base + m_size);
        taken  = pkt_valid && (m_hold.size() == 0);
        n_ptr  = m_ptr;
        n_base = m_base;
        n_size = m_size;
        e_we   = 1'b0;
        if (m_hold.size() != 0 && !full) begin
            e_we = 1'b1; e_addr = m_ptr; e_data = m_hold.pop_front();
            n_ptr = m_ptr + 32'd8;
        end else if (taken && !full) begin
            e_we = 1'b1; e_addr = m_ptr; e_data = pkt_data;
            n_ptr = m_ptr + 32'd8;
        end
        if (taken && full) m_hold.push_back(pkt_data);
        if (cfg_we) begin
            if (cfg_sel == 2'd0) begin n_base = cfg_wdata; n_ptr = cfg_wdata; end
            if (cfg_sel == 2'd1) n_size = cfg_wdata;
            if (cfg_sel == 2'd2) n_ptr = cfg_wdata;
        end
        if (irq_ack && full) n_ptr = m_base;
        @(posedge clk);
        #1;
        m_ptr = n_ptr; m_base = n_base; m_size = n_size;
        compare_all();
    endtask

    task automatic idle(input int n);
        bit t;
        for (int i = 0; i < n; i++) step(t);
    endtask

    task automatic send(input logic [1:0] src, input logic [63:0] d);
        bit t;
        pkt_valid = 1'b1; pkt_src = src; pkt_data = d;
        t = 0;
        while (!t) step(t);
        pkt_valid = 1'b0;
    endtask

    task automatic ack_pulse();
        bit t;
        irq_ack = 1'b1; step(t); irq_ack = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [31:0] v);
        bit t;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v; step(t); cfg_we = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        bit t;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);
        chk(mem_we == 1'b0, "R1 mem_we", 64'(mem_we), 64'd0);
        chk(pkt_ready == 1'b1, "R1 pkt_ready", 64'(pkt_ready), 64'd1);
        chk(wr_ptr == 32'h1000, "R1 wr_ptr", 64'(wr_ptr), 64'h1000);
        rst = 1'b0;
        idle(2);

        // R2, R3: mixed sources back to back
        send(2'd0, 64'hDEAD_BEEF_0000_0001);
        send(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        send(2'd2, 64'h0000_0000_0000_0000);
        idle(1);
        // R7: acknowledge without a pending interrupt
        irq_ack = 1'b1; step(t); irq_ack = 1'b0;
        chk(wr_ptr == 32'h1018, "R7 ptr after stray ack", 64'(wr_ptr), 64'h1018);
        send(2'd1, 64'h1234_5678_9ABC_DEF0);
        send(2'd0, 64'hA5A5_5A5A_A5A5_5A5A);
        idle(2);
        send(2'd2, 64'h0000_0000_0000_0007);
        send(2'd0, 64'h8000_0000_0000_0000);
        send(2'd1, 64'h0000_0000_0001_0000);
        idle(1);
        // R4: region full after eight words
        chk(irq == 1'b1, "R4 irq after fill", 64'(irq), 64'd1);

        // R5: one packet taken into the slot while full
        send(2'd2, 64'hC0DE_0000_0000_00AA);
        chk(pkt_ready == 1'b0, "R5 slot closes input", 64'(pkt_ready), 64'd0);
        chk(mem_we == 1'b0, "R5 held packet not written", 64'(mem_we), 64'd0);
        pkt_valid = 1'b1; pkt_src = 2'd0; pkt_data = 64'hC0DE_0000_0000_00BB;
        idle(3);
        // R6: acknowledge rewinds, held word lands at base, then the waiting one
        irq_ack = 1'b1; step(t); irq_ack = 1'b0;
        chk(wr_ptr == 32'h1000 && irq == 1'b0, "R6 rewind", 64'(wr_ptr), 64'h1000);
        step(t);
        chk(mem_we && mem_addr == 32'h1000 && mem_wdata == 64'hC0DE_0000_0000_00AA,
            "R6 held word at base", mem_wdata, 64'hC0DE_0000_0000_00AA);
        while (!t) step(t);
        pkt_valid = 1'b0;
        idle(2);

        // R8: reprogram a two-word region
        cfg(2'd1, 32'h10);
        cfg(2'd0, 32'h2000);
        chk(wr_ptr == 32'h2000, "R8 base sets pointer", 64'(wr_ptr), 64'h2000);
        send(2'd0, 64'h1111);
        send(2'd1, 64'h2222);
        idle(1);
        chk(irq == 1'b1, "R4 small region full", 64'(irq), 64'd1);
        ack_pulse();
        cfg(2'd2, 32'h2008);
        chk(wr_ptr == 32'h2008, "R8 pointer write", 64'(wr_ptr), 64'h2008);
        send(2'd2, 64'h3333);
        idle(1);
        chk(irq == 1'b1, "R4 full after pointer load", 64'(irq), 64'd1);
        ack_pulse();
        idle(2);
        summary();
    end

endmodule